// File: doc/BRIEF.md
# Zero-Sequence Injection Carrier PWM Modulator

This block turns three signed phase voltage references into three upper-switch gate demands for one two-level inverter. All three references receive one common offset, the zero-sequence component. The shifted references are then limited to the linear range, made non-negative, and compared against a shared symmetric triangular carrier. The modulator has no sector logic and does not compute dwell times. The only thing the strategy select changes is how the offset is chosen. The continuous strategy centres the largest and smallest references, which gives the same voltages as space-vector modulation. The discontinuous 60° strategy pins the phase with the largest magnitude to one DC rail for the whole carrier period.

References are scaled so that `HALF` stands for half the DC-link voltage. The normalized compare value runs from 0 to `2*HALF`. A value of `2*HALF` keeps the upper switch on for the whole period, and a value of 0 keeps the lower switch on for the whole period. Compare values change only at the carrier valley. A zero-vector input forces all three legs onto their lower switches at once, which lets the inverter act as a star point.

Top module: `zsi_pwm`

## Requirements
- R1: While reset is high and after it is released, `carrier_o` starts at 0 counting up, and every compare value is 0. All `pwm_o` bits therefore stay low until the first valley load.
- R2: The carrier is a symmetric triangle. It steps by one each clock from 0 up to `2*HALF-1`, repeats that peak value once, steps down to 0, and repeats 0 once. One period is `4*HALF` clocks.
- R3: Without the zero-vector override, a leg's `pwm_o` bit is high exactly when its compare value is greater than `carrier_o`. A compare value `c` therefore gives `2*c` high clocks per period.
- R4: Each leg's compare value is (reference + offset), limited to the range [-HALF, +HALF], plus HALF.
- R5: With `mode_i` = 0 (continuous), the offset is minus the floor of half of (largest reference + smallest reference).
- R6: With `mode_i` = 1 (discontinuous), the offset is chosen from the phase with the largest absolute reference. Ties go to a, then b, then c. The offset is +HALF minus that reference when the reference is zero or positive, and -HALF minus that reference when it is negative. That leg's output is then high for the whole period or low for the whole period.
- R7: References and `mode_i` are sampled only on the clock edge that leaves the valley, the second of the two consecutive zeros of the carrier. Changes made in the middle of a period have no effect on the current period's outputs.
- R8: While `zero_vec_i` is high, all three `pwm_o` bits are low in the same cycle, and the carrier keeps running.
- R9: `pwm_o` bit 0 drives phase a, bit 1 drives phase b, and bit 2 drives phase c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_a_i | input | REF_W | Phase a reference, signed, HALF = half DC link |
| ref_b_i | input | REF_W | Phase b reference, signed |
| ref_c_i | input | REF_W | Phase c reference, signed |
| mode_i | input | 1 | 0 continuous, 1 discontinuous 60° clamping |
| zero_vec_i | input | 1 | Force all lower switches on |
| pwm_o | output | 3 | Upper-switch demands, bit 0 = a |
| carrier_o | output | CNT_W | Triangular carrier count |

## Verification
The assertions check, on every cycle, the properties that hold regardless of stimulus:
- the carrier stays in range and moves by at most one step;
- compare values do not change except just after the valley;
- a full-scale compare holds its leg high;
- the zero-vector override silences all legs;
- after a discontinuous-mode load, at least one leg sits at a rail.

Only the bench scenarios can show the arithmetic itself: the exact offset values, including the floor rounding and the tie order, the limiting of out-of-range references, the per-period duty counts, and that a mid-period input change is ignored until the next period.

// File: rtl/zsi_pkg.sv
package zsi_pkg;

    typedef enum logic {
        ZS_CONT  = 1'b0,
        ZS_CLAMP = 1'b1
    } zs_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } car_dir_e;

    // number of bits for an unsigned count reaching value n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/zsi_carrier.sv
module zsi_carrier
    import zsi_pkg::*;
#(
    parameter int PERIOD = 128,
    parameter int CNT_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             valley_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    car_dir_e         dir_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (dir_q == DIR_UP) begin
            if (cnt_q == TOP) dir_q <= DIR_DOWN;
            else              cnt_q <= cnt_q + 1'b1;
        end else begin
            if (cnt_q == '0)  dir_q <= DIR_UP;
            else              cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign valley_o = (dir_q == DIR_DOWN) && (cnt_q == '0);

endmodule

// File: rtl/zsi_offset.sv
module zsi_offset
    import zsi_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int HALF  = 64,
    parameter int W     = REF_W + 2
) (
    input  logic signed [REF_W-1:0] ref_a_i,
    input  logic signed [REF_W-1:0] ref_b_i,
    input  logic signed [REF_W-1:0] ref_c_i,
    input  zs_mode_e                mode_i,
    output logic signed [W-1:0]     off_o
);
    localparam logic signed [W-1:0] HALF_S = W'(HALF);

    logic signed [W-1:0] va, vb, vc, mx, mn, sum_mm;
    logic signed [W-1:0] aa, ab, ac, pk, cont_off, clamp_off;

    always_comb begin
        va = W'(ref_a_i);
        vb = W'(ref_b_i);
        vc = W'(ref_c_i);

        mx = va;
        if (vb > mx) mx = vb;
        if (vc > mx) mx = vc;
        mn = va;
        if (vb < mn) mn = vb;
        if (vc < mn) mn = vc;
        sum_mm   = mx + mn;
        cont_off = -(sum_mm >>> 1);

        aa = (va < 0) ? -va : va;
        ab = (vb < 0) ? -vb : vb;
        ac = (vc < 0) ? -vc : vc;
        if (aa >= ab && aa >= ac) pk = va;
        else if (ab >= ac)        pk = vb;
        else                      pk = vc;
        clamp_off = ((pk >= 0) ? HALF_S : -HALF_S) - pk;

        off_o = (mode_i == ZS_CLAMP) ? clamp_off : cont_off;
    end

endmodule

// File: rtl/zsi_leg.sv
module zsi_leg
    import zsi_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int HALF  = 64,
    parameter int W     = REF_W + 2,
    parameter int CNT_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic signed [W-1:0]     off_i,
    input  logic                    valley_i,
    input  logic [CNT_W-1:0]        carrier_i,
    input  logic                    zero_vec_i,
    output logic [CNT_W-1:0]        cmp_o,
    output logic                    pwm_o
);
    localparam logic signed [W-1:0] HALF_S = W'(HALF);

    logic signed [W-1:0] shifted, limited, unsig;
    logic [CNT_W-1:0]    cmp_q;

    always_comb begin
        shifted = W'(ref_i) + off_i;
        if (shifted > HALF_S)       limited = HALF_S;
        else if (shifted < -HALF_S) limited = -HALF_S;
        else                        limited = shifted;
        unsig = limited + HALF_S;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)         cmp_q <= '0;
        else if (valley_i) cmp_q <= CNT_W'(unsig);
    end

    assign cmp_o = cmp_q;
    assign pwm_o = !zero_vec_i && (cmp_q > carrier_i);

endmodule

// File: rtl/zsi_pwm.sv
module zsi_pwm
    import zsi_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int HALF  = 64,
    parameter int PERIOD = 2 * HALF,
    parameter int CNT_W  = cnt_bits(2 * HALF)
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [REF_W-1:0] ref_a_i,
    input  logic signed [REF_W-1:0] ref_b_i,
    input  logic signed [REF_W-1:0] ref_c_i,
    input  logic                    mode_i,
    input  logic                    zero_vec_i,
    output logic [2:0]              pwm_o,
    output logic [CNT_W-1:0]        carrier_o
);
    localparam int W = REF_W + 2;

    logic signed [W-1:0]     off;
    logic                    valley;
    logic [CNT_W-1:0]        carrier;
    logic signed [REF_W-1:0] refs [3];
    logic [3*CNT_W-1:0]      cmp_flat;

    assign refs[0] = ref_a_i;
    assign refs[1] = ref_b_i;
    assign refs[2] = ref_c_i;

    zsi_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cnt_o    (carrier),
        .valley_o (valley)
    );

    zsi_offset #(.REF_W(REF_W), .HALF(HALF), .W(W)) u_offset (
        .ref_a_i (ref_a_i),
        .ref_b_i (ref_b_i),
        .ref_c_i (ref_c_i),
        .mode_i  (zs_mode_e'(mode_i)),
        .off_o   (off)
    );

    for (genvar g = 0; g < 3; g++) begin : g_leg
        zsi_leg #(.REF_W(REF_W), .HALF(HALF), .W(W), .CNT_W(CNT_W)) u_leg (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .ref_i      (refs[g]),
            .off_i      (off),
            .valley_i   (valley),
            .carrier_i  (carrier),
            .zero_vec_i (zero_vec_i),
            .cmp_o      (cmp_flat[g*CNT_W +: CNT_W]),
            .pwm_o      (pwm_o[g])
        );
    end

    assign carrier_o = carrier;

endmodule

// File: rtl/zsi_pwm_chk.sv
module zsi_pwm_chk #(
    parameter int HALF   = 64,
    parameter int PERIOD = 2 * HALF,
    parameter int CNT_W  = 8
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               valley_i,
    input logic               mode_i,
    input logic               zero_vec_i,
    input logic [2:0]         pwm_i,
    input logic [CNT_W-1:0]   carrier_i,
    input logic [3*CNT_W-1:0] cmp_i
);
    logic any_rail;
    logic full_ok;

    always_comb begin
        any_rail = 1'b0;
        full_ok  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (int'(cmp_i[k*CNT_W +: CNT_W]) == 0 ||
                int'(cmp_i[k*CNT_W +: CNT_W]) == PERIOD) any_rail = 1'b1;
            if (!zero_vec_i && int'(cmp_i[k*CNT_W +: CNT_W]) == PERIOD && !pwm_i[k])
                full_ok = 1'b0;
        end
    end

    p_carrier_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(carrier_i) <= PERIOD - 1);

    p_carrier_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(carrier_i) - int'($past(carrier_i)) <= 1) &&
        (int'($past(carrier_i)) - int'(carrier_i) <= 1));

    p_cmp_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valley_i |=> $stable(cmp_i));

    p_clamp_rail_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (valley_i && mode_i) |=> any_rail);

    p_full_high_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        full_ok);

    p_zero_vec_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        zero_vec_i |-> (pwm_i == 3'b000));

endmodule

bind zsi_pwm zsi_pwm_chk #(.HALF(HALF), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .valley_i   (valley),
    .mode_i     (mode_i),
    .zero_vec_i (zero_vec_i),
    .pwm_i      (pwm_o),
    .carrier_i  (carrier_o),
    .cmp_i      (cmp_flat)
);

// File: tb/test_zsi_pwm.sv
module test_zsi_pwm;
    localparam int REF_W  = 8;
    localparam int HALF   = 64;
    localparam int PERIOD = 2 * HALF;
    localparam int CNT_W  = 8;
    localparam int FULL   = 2 * PERIOD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
    logic mode = 1'b0;
    logic zv   = 1'b0;
    logic [2:0] pwm;
    logic [CNT_W-1:0] car;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    zsi_pwm #(.REF_W(REF_W), .HALF(HALF)) i_zsi_pwm (
        .clk_i(clk), .rst_i(rst), .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
        .mode_i(mode), .zero_vec_i(zv), .pwm_o(pwm), .carrier_o(car)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int c, input bit m);
        ra = REF_W'(a); rb = REF_W'(b); rc = REF_W'(c); mode = m;
    endtask

    // stop on the first sample of a new period (second of two zeros)
    task automatic sync_period();
        int prev = -1;
        forever begin
            @(negedge clk);
            if (car == 0 && prev == 0) break;
            prev = int'(car);
        end
    endtask

    // count high clocks per leg over one period; optional mid-period change
    task automatic measure(output int ha, output int hb, output int hc,
                           output int tri_err, input int chg_at,
                           input int na, input int nb, input int nc);
        ha = 0; hb = 0; hc = 0; tri_err = 0;
        for (int i = 0; i < FULL; i++) begin
            if (i == chg_at) begin ra = REF_W'(na); rb = REF_W'(nb); rc = REF_W'(nc); end
            ha += int'(pwm[0]); hb += int'(pwm[1]); hc += int'(pwm[2]);
            if (int'(car) != ((i < PERIOD) ? i : FULL - 1 - i)) tri_err++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string tag, input int a, input int b, input int c,
                            input bit m, input int ea, input int eb, input int ec);
        int ha, hb, hc, te;
        apply(a, b, c, m);
        sync_period();
        measure(ha, hb, hc, te, -1, 0, 0, 0);
        chk({tag, " leg a"}, ha, ea);
        chk({tag, " leg b"}, hb, eb);
        chk({tag, " leg c"}, hc, ec);
    endtask

    task automatic t_reset();
        int hi = 0;
        apply(20, -10, -10, 0);
        repeat (4) @(negedge clk);
        chk("R1 carrier in reset", int'(car), 0);
        chk("R1 pwm in reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 carrier counts up after reset", int'(car), 1);
        for (int i = 0; i < FULL - 2; i++) begin
            hi += int'(pwm != 0);
            @(negedge clk);
        end
        chk("R1 pwm low before first load", hi, 0);
    endtask

    task automatic t_carrier();
        int ha, hb, hc, te;
        apply(0, 0, 0, 0);
        sync_period();
        measure(ha, hb, hc, te, -1, 0, 0, 0);
        chk("R2 triangle shape mismatches", te, 0);
        chk("R3 R9 zero refs leg a", ha, PERIOD);
    endtask

    task automatic t_cont();
        // R5: off=-5 -> 15,-15,-15 -> cmp 79,49,49 (R4, R3 doubles)
        run_case("R5 cont basic", 20, -10, -10, 0, 158, 98, 98);
        // R5 floor: max+min=-1, off=+1 -> 4,1,-3 -> 68,65,61
        run_case("R5 cont floor", 3, 0, -4, 0, 136, 130, 122);
    endtask

    task automatic t_clamp();
        // R6 positive peak a=30: off 34 -> 64,24,14 -> 128,88,78
        run_case("R6 clamp pos", 30, -10, -20, 1, 256, 176, 156);
        // R6 negative peak b=-40: off -24 -> -14,-64,6 -> 50,0,70
        run_case("R6 clamp neg", 10, -40, 30, 1, 100, 0, 140);
        // R6 tie a/b -> a wins: off 44 -> 64,24,44
        run_case("R6 clamp tie", 20, -20, 0, 1, 256, 176, 216);
    endtask

    task automatic t_limit();
        // R4: off 0, a=100 limited to +64, b to -64
        run_case("R4 limit", 100, -100, 0, 0, 256, 0, 128);
    endtask

    task automatic t_force();
        int ha, hb, hc, te;
        apply(30, -10, -20, 1);
        zv = 1'b1;
        sync_period();
        measure(ha, hb, hc, te, -1, 0, 0, 0);
        chk("R8 forced leg a", ha, 0);
        chk("R8 forced leg b+c", hb + hc, 0);
        chk("R8 carrier keeps running", te, 0);
        zv = 1'b0;
        @(negedge clk);
        chk("R8 release restores leg a", int'(pwm[0]), 1);
    endtask

    task automatic t_hold();
        int ha, hb, hc, te;
        apply(20, -10, -10, 0);
        sync_period();
        measure(ha, hb, hc, te, 100, -40, 10, 30);
        chk("R7 mid-period change ignored a", ha, 158);
        chk("R7 mid-period change ignored c", hc, 98);
        // new refs take effect next period: off 5 -> -35,15,35 -> 29,79,99
        measure(ha, hb, hc, te, -1, 0, 0, 0);
        chk("R7 next period a", ha, 58);
        chk("R7 next period c", hc, 198);
    endtask

    initial begin
        t_reset();
        t_carrier();
        t_cont();
        t_clamp();
        t_limit();
        t_force();
        t_hold();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule